// File: doc/BRIEF.md
# Bubble Propagation Cluster Controller

This block is the per-cluster stall controller for a datapath built from two-phase latches. Such a datapath repairs late-arriving data by stalling locally. Each cluster groups a set of latches that share one gated clock. The controller merges the timing-error flags of its member latches into a single error. It also merges the bubble lines arriving from neighbouring clusters, which run on the opposite clock phase, into a single bubble-in. From these it decides two things. The first is whether the cluster skips its next transparent phase, shown by a low clock enable. The second is whether it sends a bubble on to its neighbours.

The block advances one step on each edge of a half-cycle clock, but only on the edges where the shared phase indicator matches the cluster's polarity parameter. Between its own edges the outputs hold. A bubble driven on one edge is therefore seen by opposite-phase neighbours half a cycle later.

A cluster stores only one bit of history, which records whether it stalled on its previous own edge. After a stall it ignores everything for one own cycle. This makes every wave of bubbles die out by itself, and each cluster stalls exactly once for each error event.

Top module: `bubble_cluster_ctl`

## Requirements
- R1: On an own edge (phaseNow equals PHASE), if any nbrBubble bit is 1 and the cluster did not stall on its previous own edge, clkEn goes to 0 and stays there until the next own edge.
- R2: A cluster that stalls on an own edge drives bubbleOut to 1 from that edge until its next own edge. Opposite-phase neighbours therefore sample it one half-cycle later.
- R3: On the own edge that follows a stall, the cluster ignores both nbrBubble and memberErr. clkEn returns to 1 and bubbleOut to 0, so the cluster never stalls on two own edges in a row.
- R4: On an own edge with no history of a stall and no neighbour bubble, a 1 on any memberErr bit sets bubbleOut to 1 while clkEn stays 1. If memberErr is also all zero, bubbleOut is 0.
- R5: Any single memberErr bit and any single nbrBubble bit is enough to trigger the response. The inputs are OR-combined.
- R6: clkEn and bubbleOut change only on own edges.
- R7: While rstN is 0, clkEn is 1 and bubbleOut is 0, whatever the inputs.
- R8: Take a ring of clusters of alternating phase, and inject one error on edge t. The source cluster stalls once, at edge t+2. Every other cluster stalls once, at edge t+d, where d is its ring distance from the source. All clkEn and bubbleOut lines are back to 1 and 0 within the event window.
- R9: Several errors close in time merge. Each cluster stalls exactly once, on the earliest edge that any source would give it under R8. An error flagged on an own edge that follows a stall has no effect.
- R10: With errors on every member of every cluster on every edge, no cluster stalls on two consecutive own edges. Every cluster stalls at least once, and on at most half of its own edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-cycle clock; one edge per clock phase |
| rstN | input | 1 | Asynchronous reset, active low |
| phaseNow | input | 1 | Phase the coming edge belongs to (0 or 1) |
| memberErr | input | MEMBERS | Timing-error flags of the member latches |
| nbrBubble | input | NBRS | Bubble lines from neighbouring clusters |
| clkEn | output | 1 | 0 means skip the next transparent phase |
| bubbleOut | output | 1 | Bubble sent to all neighbours |

## Verification
The only hidden state is the stall-history bit together with the registered bubble. A wrong value in either shows up at the ports by the cluster's next own edge. A history bit stuck at 0 gives a second stall one own edge after the first, and a bubble that echoes back. A history bit stuck at 1 swallows a stall, so a ring cluster shows a stall count of zero. A bad bubble register shifts the first-stall edge of clusters one hop away. Over a ring, each such fault appears as a wrong stall count or a wrong stall edge within a few half-cycles of the injected error.

// File: rtl/bubctl_pkg.sv
package bubctl_pkg;
  typedef struct packed {
    logic act;
    logic stall;
    logic sendBubble;
  } ctlStrobes_t;
endpackage

// File: rtl/bubctl_or_tree.sv
module bubctl_or_tree #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] leaves,
  output logic             anySet
);
  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;
  localparam int SPAN   = 1 << LEVELS;

  logic [2*SPAN-1:1] node;

  genvar li;
  generate
    for (li = 0; li < SPAN; li++) begin : gen_leaf
      if (li < WIDTH) begin : gen_real
        assign node[SPAN+li] = leaves[li];
      end else begin : gen_pad
        assign node[SPAN+li] = 1'b0;
      end
    end
    for (li = 1; li < SPAN; li++) begin : gen_node
      assign node[li] = node[2*li] | node[2*li+1];
    end
  endgenerate

  assign anySet = node[1];
endmodule

// File: rtl/bubctl_datapath.sv
module bubctl_datapath
  import bubctl_pkg::*;
#(
  parameter int MEMBERS = 8,
  parameter int NBRS    = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [MEMBERS-1:0] memberErr,
  input  logic [NBRS-1:0]    nbrBubble,
  input  ctlStrobes_t        strobes,
  output logic               errAny,
  output logic               bubAny,
  output logic               stalledLast,
  output logic               clkEn,
  output logic               bubbleOut
);
  logic stalledQ;
  logic bubbleQ;

  bubctl_or_tree #(.WIDTH(MEMBERS)) u_errTree (
    .leaves (memberErr),
    .anySet (errAny)
  );

  bubctl_or_tree #(.WIDTH(NBRS)) u_bubTree (
    .leaves (nbrBubble),
    .anySet (bubAny)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stalledQ <= 1'b0;
      bubbleQ  <= 1'b0;
    end else if (strobes.act) begin
      stalledQ <= strobes.stall;
      bubbleQ  <= strobes.sendBubble;
    end
  end

  assign stalledLast = stalledQ;
  assign clkEn       = ~stalledQ;
  assign bubbleOut   = bubbleQ;
endmodule

// File: rtl/bubctl_control.sv
module bubctl_control
  import bubctl_pkg::*;
#(
  parameter bit PHASE = 1'b0
) (
  input  logic        phaseNow,
  input  logic        errAny,
  input  logic        bubAny,
  input  logic        stalledLast,
  output ctlStrobes_t strobes
);
  logic ownEdge;
  logic eligible;

  always_comb begin
    ownEdge            = (phaseNow == PHASE);
    eligible           = ownEdge & ~stalledLast;
    strobes.act        = ownEdge;
    strobes.stall      = eligible & bubAny;
    strobes.sendBubble = eligible & (bubAny | errAny);
  end
endmodule

// File: rtl/bubble_cluster_ctl.sv
module bubble_cluster_ctl
  import bubctl_pkg::*;
#(
  parameter int MEMBERS = 8,
  parameter int NBRS    = 4,
  parameter bit PHASE   = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               phaseNow,
  input  logic [MEMBERS-1:0] memberErr,
  input  logic [NBRS-1:0]    nbrBubble,
  output logic               clkEn,
  output logic               bubbleOut
);
  ctlStrobes_t strobes;
  logic        errAny;
  logic        bubAny;
  logic        stalledLast;

  bubctl_control #(.PHASE(PHASE)) u_ctl (
    .phaseNow    (phaseNow),
    .errAny      (errAny),
    .bubAny      (bubAny),
    .stalledLast (stalledLast),
    .strobes     (strobes)
  );

  bubctl_datapath #(.MEMBERS(MEMBERS), .NBRS(NBRS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .memberErr   (memberErr),
    .nbrBubble   (nbrBubble),
    .strobes     (strobes),
    .errAny      (errAny),
    .bubAny      (bubAny),
    .stalledLast (stalledLast),
    .clkEn       (clkEn),
    .bubbleOut   (bubbleOut)
  );
endmodule

// File: rtl/bubble_cluster_ctl_chk.sv
module bubble_cluster_ctl_chk #(
  parameter int MEMBERS = 8,
  parameter int NBRS    = 4,
  parameter bit PHASE   = 1'b0
) (
  input logic               clk,
  input logic               rstN,
  input logic               phaseNow,
  input logic [MEMBERS-1:0] memberErr,
  input logic [NBRS-1:0]    nbrBubble,
  input logic               clkEn,
  input logic               bubbleOut
);
  logic ownEdge;
  assign ownEdge = (phaseNow == PHASE);

  a_r1_bubble_stalls: assert property (@(posedge clk) disable iff (!rstN)
    (ownEdge && (|nbrBubble) && clkEn) |=> !clkEn);

  a_r2_stall_forwards: assert property (@(posedge clk) disable iff (!rstN)
    (ownEdge && (|nbrBubble) && clkEn) |=> bubbleOut);

  a_r3_rest_after_stall: assert property (@(posedge clk) disable iff (!rstN)
    (ownEdge && !clkEn) |=> (clkEn && !bubbleOut));

  a_r4_error_starts: assert property (@(posedge clk) disable iff (!rstN)
    (ownEdge && (|memberErr) && !(|nbrBubble) && clkEn) |=> (clkEn && bubbleOut));

  a_r4_quiet_edge: assert property (@(posedge clk) disable iff (!rstN)
    (ownEdge && !(|memberErr) && !(|nbrBubble) && clkEn) |=> (clkEn && !bubbleOut));

  a_r6_hold_off_phase: assert property (@(posedge clk) disable iff (!rstN)
    !ownEdge |=> ($stable(clkEn) && $stable(bubbleOut)));
endmodule

bind bubble_cluster_ctl bubble_cluster_ctl_chk #(
  .MEMBERS(MEMBERS), .NBRS(NBRS), .PHASE(PHASE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .phaseNow  (phaseNow),
  .memberErr (memberErr),
  .nbrBubble (nbrBubble),
  .clkEn     (clkEn),
  .bubbleOut (bubbleOut)
);

// File: tb/bubble_cluster_ctl_bench.sv
module bubble_cluster_ctl_bench;
  localparam int N  = 4;
  localparam int M  = 3;
  localparam int NB = 2;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         phaseNow = 1'b0;
  logic [M-1:0] errIn [N];
  logic [N-1:0] en;
  logic [N-1:0] bub;

  always #2 clk = ~clk;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : gen_c
      logic [NB-1:0] nb;
      assign nb = {bub[(gi+1)%N], bub[(gi+N-1)%N]};
      bubble_cluster_ctl #(.MEMBERS(M), .NBRS(NB), .PHASE((gi % 2) == 1)) u_bubble_cluster_ctl (
        .clk       (clk),
        .rstN      (rstN),
        .phaseNow  (phaseNow),
        .memberErr (errIn[gi]),
        .nbrBubble (nb),
        .clkEn     (en[gi]),
        .bubbleOut (bub[gi])
      );
    end
  endgenerate

  int tick = 0;
  int total = 0;
  int bad = 0;
  int firstStall [N];
  int stallCnt [N];
  int lastStall [N];
  int evTick [N];
  bit evIgnore [N];
  int consec = 0;
  int phaseViol = 0;
  logic [N-1:0] prevEn = '1;
  logic [N-1:0] prevBub = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearStats();
    for (int c = 0; c < N; c++) begin
      firstStall[c] = -1;
      stallCnt[c] = 0;
      lastStall[c] = -100;
    end
    consec = 0;
  endtask

  task automatic step();
    phaseNow = ((tick % 2) == 1);
    @(posedge clk);
    #1;
    for (int c = 0; c < N; c++) begin
      if ((c % 2) == (tick % 2)) begin
        if (!en[c]) begin
          stallCnt[c]++;
          if (firstStall[c] < 0) firstStall[c] = tick;
          if (lastStall[c] == tick - 2) consec++;
          lastStall[c] = tick;
        end
      end else if (en[c] != prevEn[c] || bub[c] != prevBub[c]) begin
        phaseViol++;
      end
    end
    prevEn = en;
    prevBub = bub;
    for (int c = 0; c < N; c++) errIn[c] = '0;
    tick++;
  endtask

  function automatic int ringDist(input int a, input int b);
    int d;
    d = (a > b) ? a - b : b - a;
    return (d < N - d) ? d : N - d;
  endfunction

  task automatic runEvent(input string name, input int bitSel);
    int base;
    int exp;
    int cand;
    if ((tick % 2) != 0) step();
    base = tick;
    clearStats();
    for (int r = 0; r < 16; r++) begin
      for (int c = 0; c < N; c++)
        if (evTick[c] == r) errIn[c][bitSel] = 1'b1;
      step();
    end
    for (int c = 0; c < N; c++) begin
      exp = 1 << 20;
      for (int s = 0; s < N; s++) begin
        if (evTick[s] >= 0 && !evIgnore[s]) begin
          cand = base + evTick[s] + ((c == s) ? 2 : ringDist(c, s));
          if (cand < exp) exp = cand;
        end
      end
      check(stallCnt[c] == 1, $sformatf("R8/R9 %s cluster%0d stall count", name, c), stallCnt[c], 1);
      check(firstStall[c] == exp, $sformatf("R8/R9 %s cluster%0d stall edge", name, c), firstStall[c], exp);
    end
    check(bub == '0 && en == '1, $sformatf("R8 %s bubble-free after window", name), {en, bub}, {4'hf, 4'h0});
    for (int c = 0; c < N; c++) begin
      evTick[c] = -1;
      evIgnore[c] = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < N; c++) begin
      errIn[c] = '1;
      evTick[c] = -1;
      evIgnore[c] = 1'b0;
    end
    repeat (4) @(posedge clk);
    #1;
    // R7: reset holds outputs even with errors asserted
    check(en == '1, "R7 clkEn during reset", en, 4'hf);
    check(bub == '0, "R7 bubbleOut during reset", bub, 0);
    for (int c = 0; c < N; c++) errIn[c] = '0;
    rstN = 1'b1;
    clearStats();
    for (int i = 0; i < 6; i++) step();
    check(en == '1 && bub == '0, "R4 quiet edges keep outputs idle", {en, bub}, {4'hf, 4'h0});

    // R8, R5: single source from each cluster, each member bit
    for (int s = 0; s < N; s++) begin
      for (int b = 0; b < M; b++) begin
        evTick[s] = s % 2;
        runEvent($sformatf("single src%0d bit%0d", s, b), b);
      end
    end

    // R9: two same-phase sources merge
    evTick[0] = 0;
    evTick[2] = 0;
    runEvent("merge same phase", 1);

    // R9: opposite-phase sources half a cycle apart
    evTick[0] = 0;
    evTick[1] = 1;
    runEvent("merge staggered", 2);

    // R3/R9: error on the edge after a stall is ignored
    evTick[0] = 0;
    evTick[1] = 3;
    evIgnore[1] = 1'b1;
    evTick[3] = 3;
    evIgnore[3] = 1'b1;
    runEvent("ignored after stall", 0);

    // R4: error with no bubble sends a bubble without stalling
    if ((tick % 2) != 0) step();
    clearStats();
    errIn[2] = 3'b010;
    step();
    check(bub[2] == 1'b1, "R4 error raises bubbleOut", bub[2], 1);
    check(en[2] == 1'b1, "R4 error does not gate own clock", en[2], 1);
    step();
    check(en[1] == 1'b0 && en[3] == 1'b0, "R1 neighbours stall half-cycle later", {en[1], en[3]}, 0);
    check(bub[1] == 1'b1 && bub[3] == 1'b1, "R2 stalled neighbours forward bubble", {bub[1], bub[3]}, 3);
    step();
    check(en[1] == 1'b0 && bub[1] == 1'b1, "R6 outputs hold off own phase", {en[1], bub[1]}, 1);
    step();
    check(en[1] == 1'b1 && bub[1] == 1'b0, "R3 rest after stall", {en[1], bub[1]}, 2);
    for (int i = 0; i < 8; i++) step();

    // R10: errors everywhere on every edge
    clearStats();
    for (int i = 0; i < 40; i++) begin
      for (int c = 0; c < N; c++) errIn[c] = '1;
      step();
    end
    check(consec == 0, "R10 no consecutive stalls", consec, 0);
    for (int c = 0; c < N; c++) begin
      check(stallCnt[c] >= 1, $sformatf("R10 cluster%0d stalls under storm", c), stallCnt[c], 1);
      check(stallCnt[c] <= 10, $sformatf("R10 cluster%0d stall fraction", c), stallCnt[c], 10);
    end
    for (int i = 0; i < 10; i++) step();
    check(en == '1 && bub == '0, "R10 network settles after storm", {en, bub}, {4'hf, 4'h0});

    check(phaseViol == 0, "R6 no output change off own phase", phaseViol, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule